// File: doc/BRIEF.md
# Peripheral ID to Channel Lookup Tree Walker

The block converts a 12-bit peripheral identifier into an 8-bit channel number. It does this by walking a binary decision tree held in a table of 255 words. The identifier is the concatenation of a 4-bit slave number, in the upper bits, and an 8-bit peripheral number, in the lower bits. Each table word names one identifier bit to test and holds two branches, one for a 0 and one for a 1. A branch either points at another word or carries the final channel number.

A requester presents the slave and peripheral numbers with a valid/ready handshake. The walker then reads the table through a synchronous RAM port, one entry per cycle, starting at entry 0. It returns the channel number together with the number of entries it examined. If the walk does not end within 16 entries, or if it jumps to an index outside the table, it raises a not-found flag instead. Only one lookup is in progress at a time. Software fills the table through a separate single-word write port.

Top module: `idmap_walker`

## Requirements
- R1: The tested value is the 16-bit zero extension of {slave[3:0], peripheral[7:0]}, so selector values 12 to 15 always test a 0.
- R2: In a table word, bits [21:18] choose the identifier bit to test. For a tested 0, bit 17 is the jump flag and bits [16:9] are the field. For a tested 1, bit 8 is the jump flag and bits [7:0] are the field.
- R3: A jump flag of 0 ends the walk: the response carries the field as its channel number, with not-found low.
- R4: Every walk starts at entry 0. A jump flag of 1 makes the next examined entry the one whose index is the field.
- R5: If the 16th examined entry still asks for a jump, the response reports not-found with a step count of 16. A result found at the 16th entry is returned normally.
- R6: A jump to index 255 ends the walk at once. The response reports not-found, and its step count includes the entry that asked for the jump.
- R7: Outside reset and between lookups, request ready is high. It falls at the edge that accepts a request and stays low until the edge that consumes the response. Request inputs that change while the block is busy have no effect.
- R8: While the response is valid and response ready is low, the response fields hold steady.
- R9: The step count equals the number of table entries examined, from 1 to 16. The response becomes valid exactly that many clock edges after the acceptance edge.
- R10: A table write at a clock edge replaces that entry for all later lookups.
- R11: During and right after reset, request ready is high and response valid is low.
- R12: Whenever not-found is reported, the channel output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_sid_i | input | 4 | Slave number (upper identifier bits) |
| req_per_i | input | 8 | Peripheral number (lower identifier bits) |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumed |
| rsp_chan_o | output | 8 | Channel number found |
| rsp_miss_o | output | 1 | Not-found flag |
| rsp_steps_o | output | 5 | Number of table entries examined |
| tbl_we_i | input | 1 | Table write enable |
| tbl_waddr_i | input | 8 | Table write index |
| tbl_wdata_i | input | 32 | Table write data |

## Verification
The bound assertions check the handshake rules on every cycle:
- ready and valid are never high together;
- ready drops after acceptance;
- the response holds steady under back-pressure;
- the step count stays in range;
- a not-found response carries channel 0.

A counter in the checker also ties the response latency to the reported step count. Whether the channel number and the not-found decision are correct depends on the table contents, so only the bench scenarios can show it. Those scenarios cover:
- single-step results on each branch;
- selectors above the identifier width;
- jumps to index 255;
- a chain that ends exactly at the 16th entry, and one that runs past it;
- a rewritten table entry.

// File: rtl/idmap_pkg.sv
package idmap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_RESP = 2'd2
  } walk_state_e;
endpackage

// File: rtl/idmap_table_ram.sv
module idmap_table_ram #(
  parameter int unsigned DEPTH  = 255,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W:0] DEPTH_L = DEPTH[ADDR_W:0];

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && ({1'b0, waddr_i} < DEPTH_L)) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (re_i) rdata_o <= ({1'b0, raddr_i} < DEPTH_L) ? mem_q[raddr_i] : '0;
  end
endmodule

// File: rtl/idmap_node_decode.sv
module idmap_node_decode #(
  parameter int unsigned ID_W    = 12,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned ENTRY_W = 32
) (
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic [ID_W-1:0]    id_i,
  output logic               cont_o,
  output logic [IDX_W-1:0]   target_o
);
  localparam int unsigned TEST_W  = 2 ** SEL_W;
  localparam int unsigned LO_FLAG = IDX_W;
  localparam int unsigned HI_LSB  = IDX_W + 1;
  localparam int unsigned HI_FLAG = 2 * IDX_W + 1;
  localparam int unsigned SEL_LSB = 2 * IDX_W + 2;

  logic [TEST_W-1:0] id_ext;
  logic [SEL_W-1:0]  sel;
  logic              bit_val;
  logic              unused_hi;

  assign id_ext    = TEST_W'(id_i);
  assign sel       = entry_i[SEL_LSB +: SEL_W];
  assign bit_val   = id_ext[sel];
  assign unused_hi = ^entry_i[ENTRY_W-1:SEL_LSB+SEL_W];

  always_comb begin
    if (bit_val) begin
      cont_o   = entry_i[LO_FLAG];
      target_o = entry_i[0 +: IDX_W];
    end else begin
      cont_o   = entry_i[HI_FLAG];
      target_o = entry_i[HI_LSB +: IDX_W];
    end
  end
endmodule

// File: rtl/idmap_walk_ctrl.sv
module idmap_walk_ctrl
  import idmap_pkg::*;
#(
  parameter int unsigned ID_W      = 12,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned DEPTH     = 255,
  parameter int unsigned MAX_STEPS = 16,
  parameter int unsigned STEP_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ID_W-1:0]   req_id_i,
  output logic [ID_W-1:0]   id_o,
  input  logic              node_cont_i,
  input  logic [IDX_W-1:0]  node_target_i,
  output logic              ram_re_o,
  output logic [IDX_W-1:0]  ram_raddr_o,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [IDX_W-1:0]  rsp_chan_o,
  output logic              rsp_miss_o,
  output logic [STEP_W-1:0] rsp_steps_o
);
  localparam logic [IDX_W:0]  DEPTH_L = DEPTH[IDX_W:0];
  localparam logic [STEP_W-1:0] MAX_L = MAX_STEPS[STEP_W-1:0];

  walk_state_e       state_q;
  logic [STEP_W-1:0] steps_q, steps_n;
  logic              jump_ok;

  assign steps_n     = steps_q + STEP_W'(1);
  assign jump_ok     = node_cont_i && ({1'b0, node_target_i} < DEPTH_L) && (steps_n < MAX_L);
  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RESP);

  always_comb begin
    ram_re_o    = 1'b0;
    ram_raddr_o = '0;
    unique case (state_q)
      ST_IDLE: ram_re_o = req_valid_i;
      ST_WALK: if (jump_ok) begin
        ram_re_o    = 1'b1;
        ram_raddr_o = node_target_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      steps_q     <= '0;
      id_o        <= '0;
      rsp_chan_o  <= '0;
      rsp_miss_o  <= 1'b0;
      rsp_steps_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          id_o    <= req_id_i;
          steps_q <= '0;
          state_q <= ST_WALK;
        end
        ST_WALK: begin
          if (jump_ok) begin
            steps_q <= steps_n;
          end else begin
            rsp_steps_o <= steps_n;
            rsp_miss_o  <= node_cont_i;
            rsp_chan_o  <= node_cont_i ? '0 : node_target_i;
            state_q     <= ST_RESP;
          end
        end
        ST_RESP: if (rsp_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idmap_walker.sv
module idmap_walker #(
  parameter int unsigned SID_W     = 4,
  parameter int unsigned PER_W     = 8,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned ENTRY_W   = 32,
  parameter int unsigned DEPTH     = 255,
  parameter int unsigned MAX_STEPS = 16,
  parameter int unsigned STEP_W    = $clog2(MAX_STEPS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [SID_W-1:0]   req_sid_i,
  input  logic [PER_W-1:0]   req_per_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [IDX_W-1:0]   rsp_chan_o,
  output logic               rsp_miss_o,
  output logic [STEP_W-1:0]  rsp_steps_o,
  input  logic               tbl_we_i,
  input  logic [IDX_W-1:0]   tbl_waddr_i,
  input  logic [ENTRY_W-1:0] tbl_wdata_i
);
  localparam int unsigned ID_W = SID_W + PER_W;

  logic [ID_W-1:0]    id_q;
  logic               ram_re;
  logic [IDX_W-1:0]   ram_raddr;
  logic [ENTRY_W-1:0] ram_rdata;
  logic               node_cont;
  logic [IDX_W-1:0]   node_target;

  idmap_table_ram #(.DEPTH(DEPTH), .DATA_W(ENTRY_W), .ADDR_W(IDX_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_waddr_i),
    .wdata_i (tbl_wdata_i),
    .re_i    (ram_re),
    .raddr_i (ram_raddr),
    .rdata_o (ram_rdata)
  );

  idmap_node_decode #(.ID_W(ID_W), .IDX_W(IDX_W), .SEL_W(SEL_W), .ENTRY_W(ENTRY_W)) u_dec (
    .entry_i  (ram_rdata),
    .id_i     (id_q),
    .cont_o   (node_cont),
    .target_o (node_target)
  );

  idmap_walk_ctrl #(
    .ID_W(ID_W), .IDX_W(IDX_W), .DEPTH(DEPTH), .MAX_STEPS(MAX_STEPS), .STEP_W(STEP_W)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .req_id_i      ({req_sid_i, req_per_i}),
    .id_o          (id_q),
    .node_cont_i   (node_cont),
    .node_target_i (node_target),
    .ram_re_o      (ram_re),
    .ram_raddr_o   (ram_raddr),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_ready_i   (rsp_ready_i),
    .rsp_chan_o    (rsp_chan_o),
    .rsp_miss_o    (rsp_miss_o),
    .rsp_steps_o   (rsp_steps_o)
  );
endmodule

// File: rtl/idmap_walker_chk.sv
module idmap_walker_chk #(
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned MAX_STEPS = 16,
  parameter int unsigned STEP_W    = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [IDX_W-1:0]  rsp_chan_o,
  input logic              rsp_miss_o,
  input logic [STEP_W-1:0] rsp_steps_o
);
  localparam logic [STEP_W-1:0] MAX_L = MAX_STEPS[STEP_W-1:0];

  logic [STEP_W:0] lat_q;

  // cycles since acceptance while walking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else if (req_valid_i && req_ready_o) lat_q <= '0;
    else if (!req_ready_o && !rsp_valid_o && lat_q != '1) lat_q <= lat_q + 1'b1;
  end

  p_one_in_flight_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_ready_o && rsp_valid_o));

  p_busy_after_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_hold_rsp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_chan_o) && $stable(rsp_miss_o) && $stable(rsp_steps_o)));

  p_steps_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_steps_o != '0 && rsp_steps_o <= MAX_L));

  p_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> (lat_q == {1'b0, rsp_steps_o}));

  p_miss_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_miss_o) |-> (rsp_chan_o == '0));

  always_comb begin
    if (!rst_ni) p_reset_idle_r11: assert (!rsp_valid_o && req_ready_o);
  end
endmodule

bind idmap_walker idmap_walker_chk #(.IDX_W(IDX_W), .MAX_STEPS(MAX_STEPS), .STEP_W(STEP_W)) u_chk (.*);

// File: tb/tb_idmap_walker.sv
module tb_idmap_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_sid = '0;
  logic [7:0]  req_per = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [7:0]  rsp_chan;
  logic        rsp_miss;
  logic [4:0]  rsp_steps;
  logic        tbl_we = 1'b0;
  logic [7:0]  tbl_waddr = '0;
  logic [31:0] tbl_wdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit started = 0;

  always #4 clk = ~clk;

  idmap_walker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_sid_i(req_sid), .req_per_i(req_per),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_chan_o(rsp_chan), .rsp_miss_o(rsp_miss), .rsp_steps_o(rsp_steps),
    .tbl_we_i(tbl_we), .tbl_waddr_i(tbl_waddr), .tbl_wdata_i(tbl_wdata)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int sel, input bit f0, input int v0, input bit f1, input int v1);
    logic [31:0] e = '0;
    e[21:18] = 4'(sel);
    e[17]    = f0;
    e[16:9]  = 8'(v0);
    e[8]     = f1;
    e[7:0]   = 8'(v1);
    return e;
  endfunction

  // behavioural reference
  logic [31:0] m_tbl [255];
  int   m_state = 0;
  int   m_left = 0;
  int   m_chan = 0;
  bit   m_miss = 0;
  int   m_steps = 0;
  bit   m_was_resp = 0;

  task automatic model_walk(input logic [11:0] id, output int chan, output bit miss, output int steps);
    logic [15:0] v = {4'b0, id};
    int idx = 0;
    chan = 0; miss = 1; steps = 16;
    for (int i = 0; i < 16; i++) begin
      logic [31:0] e = m_tbl[idx];
      bit b = v[e[21:18]];
      bit f = b ? e[8] : e[17];
      int fld = b ? int'(e[7:0]) : int'(e[16:9]);
      if (!f) begin chan = fld; miss = 0; steps = i + 1; return; end
      if (fld >= 255) begin steps = i + 1; return; end
      idx = fld;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 0;
    end else begin
      if (tbl_we && tbl_waddr < 8'd255) m_tbl[tbl_waddr] <= tbl_wdata;
      case (m_state)
        0: if (req_valid) begin
          int c; bit m; int s;
          model_walk({req_sid, req_per}, c, m, s);
          m_chan <= c; m_miss <= m; m_steps <= s; m_left <= s;
          m_state <= 1;
        end
        1: begin
          if (m_left == 1) m_state <= 2;
          m_left <= m_left - 1;
        end
        default: if (rsp_ready) m_state <= 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && started) begin
      string rq;
      chk(req_ready === (m_state == 0), "R7", "req_ready", int'(req_ready), int'(m_state == 0));
      chk(rsp_valid === (m_state == 2), "R9", "rsp_valid", int'(rsp_valid), int'(m_state == 2));
      if (m_state == 2) begin
        rq = m_was_resp ? "R8" : (!m_miss ? "R3" : (m_steps == 16 ? "R5" : "R6"));
        chk(rsp_chan === 8'(m_chan), rq, "rsp_chan", int'(rsp_chan), m_chan);
        chk(rsp_miss === m_miss, rq, "rsp_miss", int'(rsp_miss), int'(m_miss));
        chk(rsp_steps === 5'(m_steps), "R9", "rsp_steps", int'(rsp_steps), m_steps);
      end
      m_was_resp = (m_state == 2) && !rsp_ready;
    end
  end

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = 8'(addr); tbl_wdata = data;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic lookup(input int sid, input int per, input int hold,
                        input int e_chan, input bit e_miss, input int e_steps, input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_sid = 4'(sid); req_per = 8'(per);
    @(negedge clk);
    req_valid = 1'b0; req_sid = ~4'(sid); req_per = ~8'(per);  // R7: ignored while busy
    while (!rsp_valid) @(negedge clk);
    repeat (hold) @(negedge clk);
    chk(rsp_chan === 8'(e_chan), tag, "chan", int'(rsp_chan), e_chan);
    chk(rsp_miss === e_miss, tag, "miss", int'(rsp_miss), int'(e_miss));
    chk(rsp_steps === 5'(e_steps), tag, "steps", int'(rsp_steps), e_steps);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R11", "ready in reset", int'(req_ready), 1);
    chk(rsp_valid === 1'b0, "R11", "valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R11", "ready after reset", int'(req_ready), 1);
    chk(rsp_valid === 1'b0, "R11", "valid after reset", int'(rsp_valid), 0);
    for (int i = 0; i < 255; i++) wr(i, 32'h0);
    started = 1;

    // R2/R3: one-step results on both branches
    wr(0, mk(0, 0, 8'h11, 0, 8'h22));
    lookup(0, 8'h00, 0, 8'h11, 0, 1, "R2");
    lookup(0, 8'h01, 0, 8'h22, 0, 1, "R3");

    // R1/R4/R6 tree: entry0 tests id bit 8 (slave bit 0)
    wr(0,   mk(8,  1, 5,     1, 254));
    wr(5,   mk(15, 0, 8'h5A, 0, 8'h99));
    wr(254, mk(11, 0, 8'h77, 1, 255));
    lookup(2, 8'hFF, 0, 8'h5A, 0, 2, "R1");
    lookup(1, 8'h00, 3, 8'h77, 0, 2, "R4");
    lookup(9, 8'h00, 2, 0, 1, 2, "R6");
    lookup(9, 8'h00, 0, 0, 1, 2, "R12");
    for (int s = 0; s < 16; s++) lookup(s, 8'h3C, s % 3,
      (s % 2 == 0) ? 8'h5A : ((s >= 8) ? 0 : 8'h77), (s % 2 == 1) && (s >= 8), 2, "R4");

    // R5: chain 0 -> 20 .. 34, result at the 16th entry
    wr(0, mk(0, 1, 20, 1, 20));
    for (int i = 20; i < 34; i++) wr(i, mk(0, 1, i + 1, 1, i + 1));
    wr(34, mk(0, 0, 8'hC3, 0, 8'hC3));
    lookup(0, 0, 0, 8'hC3, 0, 16, "R5");
    wr(34, mk(0, 1, 35, 1, 35));
    lookup(0, 0, 1, 0, 1, 16, "R5");

    // R10: rewrite entry 0
    wr(0, mk(0, 0, 8'hAB, 0, 8'hAB));
    lookup(3, 8'h10, 0, 8'hAB, 0, 1, "R10");

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule